// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a synthesizable model of a synchronous static RAM that serves four-beat bursts. Its word is 36 bits wide, made of four byte lanes. Each lane holds eight data bits and one parity bit. All control inputs are captured on the rising clock edge, with three exceptions: the output enable and the sleep input act at once, and the burst-order select is expected to be held steady.

A burst starts on one of two start strobes.

- The processor-side strobe always opens a read.
- The controller-side strobe samples the write controls on its own edge, so it can open either a read or a write.

After a burst has started, the advance input steps through the four beats or holds the current beat as a wait state. The order is either a wrapping count or an XOR order. Read data leaves through two registers. A separate drive-enable output takes the place of a three-state bus. The sleep input freezes the block, and a two-cycle wake window follows it.

Top module: `burst_sram`

## Requirements
- R1: After a synchronous reset, rdata_en and proto_err are 0 and rdata is all zeros.
- R2: The device is selected only when cs1_n=0, cs2=1 and cs2_n=0. A start strobe sampled while the device is not selected performs no access and ends any burst in progress, so no read data is driven afterwards.
- R3: When strb_cpu_n=0 and cs1_n=0 on a selected edge, a read burst starts at addr. On that edge, gwr_n, bwr_n, lane_wr_n, adv_n and strb_ctl_n have no effect.
- R4: When cs1_n=1, strb_cpu_n has no effect. With strb_ctl_n high, such an edge behaves as a continue edge of the current burst.
- R5: A controller strobe (strb_ctl_n=0, with the processor strobe not active) on a selected edge starts a burst at addr. It writes on that same edge if the write decode calls for a write, and otherwise it reads.
- R6: On a continue edge (no start strobe) of an open burst with adv_n=0, the two low address bits step to (start + n) mod 4 when ileave=0. The upper address bits stay fixed, and after the fourth beat the order wraps back to the start.
- R7: With ileave=1, the n-th beat uses low address bits start XOR n.
- R8: A continue edge with adv_n=1 accesses the same address again.
- R9: Write decode works as follows. gwr_n=0 writes all lanes. Otherwise, bwr_n=0 writes each lane i whose lane_wr_n[i]=0. Lane i covers bits [9i+8:9i]. Any other combination is a read.
- R10: The data read on edge k appears on rdata just after edge k+1.
- R11: rdata_en is 0 for the cycle after any edge that performed a write, whatever oe_n is. Otherwise it follows a valid second-stage read, and it changes at once with oe_n (drive only when oe_n=0).
- R12: While sleep=1, rdata_en is 0 at once and no edge performs an access. Memory contents are preserved.
- R13: For the 2 edges after sleep falls, start strobes are ignored and no access happens. proto_err is 1 during the cycle after any such edge that saw a strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor-side burst start strobe, active low |
| strb_ctl_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | External start address |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ileave | input | 1 | Burst order: 0 wrapping count, 1 XOR order |
| sleep | input | 1 | Power-down request, active high |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_en | output | 1 | Drive enable for rdata |
| proto_err | output | 1 | Strobe seen inside the wake window |

## Verification
The most delicate overlap is a write edge that lands while the preceding read is still sitting in the second output register. The drive must drop in that very cycle, and that read's data is never shown. The bench provokes this by issuing a read start followed directly by a write start with oe_n held low. It judges the result against a behavioural model that tracks both pipeline stages and the write flag independently, and a directed check confirms that rdata_en is low. A second overlap is a start strobe placed on the first wake edge. There the bench checks that the access is dropped and that proto_err rises.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // low address bits of beat `step` given the start bits
  function automatic logic [BURST_W-1:0] beat_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               xor_order
  );
    return xor_order ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/bsram_wdec.sv
module bsram_wdec #(
  parameter int LANES = 4
) (
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lanes,
  output logic             is_wr
);
  always_comb begin
    if (!gwr_n)      lanes = '1;
    else if (!bwr_n) lanes = ~lane_wr_n;
    else             lanes = '0;
    is_wr = |lanes;
  end
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs2_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              ileave,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_wr,
  output acc_e              acc,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              proto_err
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);

  logic              open_q, open_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] step_q, step_d;
  logic [WK_W-1:0]   wake_q;
  logic              err_q;

  logic sel, cpu_go, ctl_go, awake;

  always_comb begin
    sel    = !cs1_n && cs2 && !cs2_n;
    cpu_go = !strb_cpu_n && !cs1_n;
    ctl_go = !strb_ctl_n && !cpu_go;
    awake  = !sleep && (wake_q == '0);
    open_d = open_q;
    base_d = base_q;
    step_d = step_q;
    acc    = ACC_IDLE;
    if (awake) begin
      if (cpu_go) begin
        open_d = sel;
        if (sel) begin
          base_d = addr;
          step_d = '0;
          acc    = ACC_READ;
        end
      end else if (ctl_go) begin
        open_d = sel;
        if (sel) begin
          base_d = addr;
          step_d = '0;
          acc    = is_wr ? ACC_WRITE : ACC_READ;
        end
      end else if (open_q) begin
        if (!adv_n) step_d = step_q + 1'b1;
        acc = is_wr ? ACC_WRITE : ACC_READ;
      end
    end
    acc_addr = {base_d[ADDR_W-1:BURST_W], beat_low(base_d[BURST_W-1:0], step_d, ileave)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      base_q <= '0;
      step_q <= '0;
      wake_q <= '0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      base_q <= base_d;
      step_q <= step_d;
      if (sleep)               wake_q <= WK_W'(WAKE_CYC);
      else if (wake_q != '0)   wake_q <= wake_q - 1'b1;
      err_q <= !sleep && (wake_q != '0) && (!strb_cpu_n || !strb_ctl_n);
    end
  end

  assign proto_err = err_q;

  // R13: the error flag only follows an edge inside the wake window
  p_err_src_r13: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(wake_q != '0));

  // R2: a processor strobe on a deselected edge performs no access
  p_desel_r2: assert property (@(posedge clk) disable iff (rst)
    (awake && cpu_go && !(cs2 && !cs2_n)) |-> (acc == ACC_IDLE));
endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lanes,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (wr_en && lanes[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)             q_r       <= mem[addr];
    end
    assign q[g*LANE_W +: LANE_W] = q_r;
  end
endmodule

// File: rtl/bsram_opipe.sv
module bsram_opipe #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] s1_data,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_en,
  output logic              s2_vld
);
  logic s1_vld, wr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      wr_seen <= 1'b0;
      rdata   <= '0;
    end else begin
      s1_vld  <= rd_en;
      s2_vld  <= s1_vld;
      wr_seen <= wr_en;
      if (s1_vld) rdata <= s1_data;
    end
  end

  assign rdata_en = s2_vld && !wr_seen && !oe_n && !sleep;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs2_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    ileave,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en,
  output logic                    proto_err
);
  localparam int WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  wr_lanes;
  logic              is_wr;
  acc_e              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic              rd_req, wr_req, s2_vld;
  logic [WORD_W-1:0] s1_data;

  bsram_wdec #(.LANES(LANES)) i_wdec (
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .lanes(wr_lanes), .is_wr(is_wr)
  );

  bsram_seq #(.ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC)) i_seq (
    .clk(clk), .rst(rst), .sleep(sleep),
    .cs1_n(cs1_n), .cs2(cs2), .cs2_n(cs2_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .adv_n(adv_n), .ileave(ileave), .addr(addr), .is_wr(is_wr),
    .acc(acc), .acc_addr(acc_addr), .proto_err(proto_err)
  );

  assign rd_req = (acc == ACC_READ);
  assign wr_req = (acc == ACC_WRITE);

  bsram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_lanes (
    .clk(clk), .wr_en(wr_req), .rd_en(rd_req), .lanes(wr_lanes),
    .addr(acc_addr), .wdata(wdata), .q(s1_data)
  );

  bsram_opipe #(.WORD_W(WORD_W)) i_opipe (
    .clk(clk), .rst(rst), .rd_en(rd_req), .wr_en(wr_req),
    .s1_data(s1_data), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_en(rdata_en), .s2_vld(s2_vld)
  );

  // R10: a read reaches the output stage two edges later
  p_rd_lat_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ##1 s2_vld);

  // R11: a sampled write silences the drive in the following cycle
  p_wr_mute_r11: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !rdata_en);

  // R12: sleep keeps the outputs off
  p_sleep_mute_r12: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !rdata_en);

  // R13: the first edge after sleep falls performs no access
  p_wake_block_r13: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> !(rd_req || wr_req));

  // R9: every write touches at least one lane
  p_wr_lane_r9: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_lanes != '0));
endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs1_n, cs2, cs2_n, strb_cpu_n, strb_ctl_n, adv_n;
  logic [7:0]  addr;
  logic        gwr_n, bwr_n;
  logic [3:0]  lane_wr_n;
  logic [35:0] wdata;
  logic        oe_n, ileave, sleep;
  logic [35:0] rdata;
  logic        rdata_en, proto_err;

  int total = 0;
  int bad   = 0;

  burst_sram i_burst_sram (
    .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .cs2_n(cs2_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .addr(addr), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .wdata(wdata), .oe_n(oe_n), .ileave(ileave), .sleep(sleep),
    .rdata(rdata), .rdata_en(rdata_en), .proto_err(proto_err)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [35:0] mm [256];
  bit          m_open, m_v1, m_v2, m_ws, m_err;
  int          m_wake, m_base, m_step, m_op, m_a;
  logic [35:0] m_q1, m_rd;
  logic [3:0]  m_ln;
  bit          m_sel, m_pgo, m_cgo;

  initial for (int i = 0; i < 256; i++) mm[i] = 'x;

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_wake = 0; m_v1 = 0; m_v2 = 0; m_ws = 0; m_err = 0;
      m_rd = '0; m_base = 0; m_step = 0;
    end else begin
      m_op = 0;
      if (!gwr_n) m_ln = 4'hf; else if (!bwr_n) m_ln = ~lane_wr_n; else m_ln = 4'h0;
      m_err = 0;
      if (sleep) m_wake = 2;
      else if (m_wake > 0) begin
        m_err = !strb_cpu_n || !strb_ctl_n;
        m_wake--;
      end else begin
        m_sel = !cs1_n && cs2 && !cs2_n;
        m_pgo = !strb_cpu_n && !cs1_n;
        m_cgo = !strb_ctl_n && !m_pgo;
        if (m_pgo || m_cgo) begin
          m_open = m_sel;
          if (m_sel) begin
            m_base = addr; m_step = 0;
            m_op = (m_cgo && m_ln != 0) ? 2 : 1;
          end
        end else if (m_open) begin
          if (!adv_n) m_step = (m_step + 1) % 4;
          m_op = (m_ln != 0) ? 2 : 1;
        end
      end
      m_a = (m_base & ~3) | (ileave ? ((m_base & 3) ^ m_step) : (((m_base & 3) + m_step) % 4));
      m_v2 = m_v1;
      if (m_v1) m_rd = m_q1;
      m_v1 = (m_op == 1);
      if (m_op == 1) m_q1 = mm[m_a];
      if (m_op == 2)
        for (int l = 0; l < 4; l++)
          if (m_ln[l]) mm[m_a][l*9 +: 9] = wdata[l*9 +: 9];
      m_ws = (m_op == 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_en;
    exp_en = m_v2 && !m_ws && !oe_n && !sleep;
    chk(rdata_en === exp_en, "R11 model drive enable", 36'(rdata_en), 36'(exp_en));
    chk(proto_err === m_err, "R13 model protocol flag", 36'(proto_err), 36'(m_err));
    if (exp_en && !$isunknown(m_rd))
      chk(rdata === m_rd, "R10 model read data", rdata, m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
    compare();
  endtask

  task automatic idle();
    cs1_n = 0; cs2 = 1; cs2_n = 0; strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
    gwr_n = 1; bwr_n = 1; lane_wr_n = 4'hf; oe_n = 0; sleep = 0;
  endtask

  localparam logic [35:0] A0 = 36'h0A1B2C3D4, A1 = 36'h155667788;
  localparam logic [35:0] A2 = 36'h099AABBCC, A3 = 36'h1DDEEFF00;
  localparam logic [35:0] W0 = 36'h0F0F0F0F0, W1 = 36'h123456789, W2 = 36'h0CAFE0001;
  localparam logic [35:0] LMASK = {9'h000, 9'h1ff, 9'h000, 9'h1ff};

  initial begin
    #(64'd20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); ileave = 0; addr = '0; wdata = '0; rst = 1;
    @(negedge clk);
    tick(); tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(rdata_en === 1'b0, "R1 rdata_en after reset", 36'(rdata_en), 36'd0);
    chk(proto_err === 1'b0, "R1 proto_err after reset", 36'(proto_err), 36'd0);
    chk(rdata === 36'd0, "R1 rdata after reset", rdata, 36'd0);

    // R5/R6: controller-strobe write burst from 0x12, linear wrap
    idle(); strb_ctl_n = 0; addr = 8'h12; gwr_n = 0; wdata = A0; tick();
    idle(); adv_n = 0; gwr_n = 0; wdata = A1; tick();
    idle(); adv_n = 0; gwr_n = 0; wdata = A2; tick();
    idle(); adv_n = 0; gwr_n = 0; wdata = A3; tick();

    // R3/R8/R10/R6: processor read with write enables and advance low (ignored)
    idle(); strb_cpu_n = 0; addr = 8'h12; gwr_n = 0; adv_n = 0; wdata = W2; tick();
    idle(); tick();
    chk(rdata === A0, "R3 R10 first beat", rdata, A0);
    chk(rdata_en === 1'b1, "R11 drive on read", 36'(rdata_en), 36'd1);
    idle(); adv_n = 0; tick();
    chk(rdata === A0, "R8 wait state repeats", rdata, A0);
    idle(); adv_n = 0; tick();
    chk(rdata === A1, "R6 linear beat", rdata, A1);
    idle(); adv_n = 0; tick();
    chk(rdata === A2, "R6 linear wrap", rdata, A2);
    idle(); tick();
    chk(rdata === A3, "R6 last beat", rdata, A3);

    // R7: interleaved order from 0x13
    ileave = 1;
    idle(); strb_cpu_n = 0; addr = 8'h13; tick();
    idle(); adv_n = 0; tick();
    chk(rdata === A1, "R7 beat0", rdata, A1);
    idle(); adv_n = 0; tick();
    chk(rdata === A0, "R7 beat1", rdata, A0);
    idle(); adv_n = 0; tick();
    chk(rdata === A3, "R7 beat2", rdata, A3);
    idle(); tick();
    chk(rdata === A2, "R7 beat3", rdata, A2);
    ileave = 0;

    // R4: cs1_n high blocks the processor strobe -> continue
    idle(); strb_cpu_n = 0; addr = 8'h12; tick();
    idle(); cs1_n = 1; strb_cpu_n = 0; addr = 8'h20; adv_n = 0; tick();
    idle(); strb_ctl_n = 0; cs2 = 0; tick();
    chk(rdata === A1, "R4 blocked strobe continues", rdata, A1);
    // R2: deselected strobes start nothing
    idle(); strb_cpu_n = 0; cs2_n = 1; addr = 8'h12; tick();
    idle(); tick();
    chk(rdata_en === 1'b0, "R2 no drive after deselect", 36'(rdata_en), 36'd0);

    // R9/R11: byte write merge and write-after-read mute
    idle(); strb_ctl_n = 0; addr = 8'h20; gwr_n = 0; wdata = W0; tick();
    idle(); strb_ctl_n = 0; addr = 8'h20; bwr_n = 0; lane_wr_n = 4'b1010; wdata = W1; tick();
    idle(); strb_ctl_n = 0; addr = 8'h20; lane_wr_n = 4'b0000; tick();
    idle(); strb_ctl_n = 0; addr = 8'h21; gwr_n = 0; wdata = W2; tick();
    chk(rdata_en === 1'b0, "R11 write mutes pending read", 36'(rdata_en), 36'd0);
    idle(); strb_ctl_n = 0; addr = 8'h20; tick();
    idle(); tick();
    chk(rdata === ((W1 & LMASK) | (W0 & ~LMASK)), "R9 lane merge", rdata,
        (W1 & LMASK) | (W0 & ~LMASK));
    chk(rdata_en === 1'b1, "R9 read drives", 36'(rdata_en), 36'd1);
    oe_n = 1; #1;
    chk(rdata_en === 1'b0, "R11 oe_n async off", 36'(rdata_en), 36'd0);
    oe_n = 0; #1;
    chk(rdata_en === 1'b1, "R11 oe_n async on", 36'(rdata_en), 36'd1);

    // R12/R13: sleep and wake window
    idle(); strb_cpu_n = 0; addr = 8'h12; tick();
    idle(); tick();
    sleep = 1; #1;
    chk(rdata_en === 1'b0, "R12 sleep mutes", 36'(rdata_en), 36'd0);
    idle(); sleep = 1; strb_ctl_n = 0; addr = 8'h12; gwr_n = 0; wdata = W2; tick();
    idle(); sleep = 1; tick();
    idle(); sleep = 1; tick();
    idle(); strb_cpu_n = 0; addr = 8'h13; tick();
    chk(proto_err === 1'b1, "R13 strobe in wake window", 36'(proto_err), 36'd1);
    idle(); tick();
    chk(proto_err === 1'b0, "R13 flag clears", 36'(proto_err), 36'd0);
    chk(rdata_en === 1'b0, "R13 strobe ignored", 36'(rdata_en), 36'd0);
    idle(); strb_cpu_n = 0; addr = 8'h12; tick();
    idle(); tick();
    chk(rdata === A0, "R12 contents preserved", rdata, A0);
    chk(rdata_en === 1'b1, "R13 access after wake", 36'(rdata_en), 36'd1);

    idle(); tick(); tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule